// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous static memory that never needs an idle cycle on its data buses when the traffic switches between reads and writes. Every input is captured on the rising clock edge: address, chip enables, write enable, byte write enables and the burst advance. Write data arrives late. It is taken one edge after the write command in flow-through operation and two edges after it in pipelined operation. Because the write is late, a read can be issued in the cycle right after a write, and a write right after a read. A read that targets a write still waiting for its data is served by forwarding that data as it arrives.

A static mode input selects the read path. In pipelined mode, read data passes through an output register. In flow-through mode, the array output drives the bus directly. A three-state burst controller (ST_IDLE, ST_RD, ST_WR) keeps the start address of the current burst. When the advance input is high, it steps through four beats of the two low address bits, in linear or interleaved order. The other controls are a global clock enable that freezes the whole pipeline, three chip enables of mixed polarity for depth expansion, and an asynchronous output enable that gates the read bus.

Burst controller transitions:
- ST_IDLE → ST_RD on a selected read, and ST_IDLE → ST_WR on a selected write.
- ST_IDLE → ST_IDLE on advance, and on a cycle that is not selected.
- ST_RD or ST_WR → the same state on advance (the burst continues).
- ST_RD or ST_WR → ST_RD or ST_WR on a new selected command.
- ST_RD or ST_WR → ST_IDLE on a cycle that is not selected.

Top module: `zt_sram`

## Requirements
- R1: When `adv` is 0, a new command is accepted only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect cycle: it performs no read and no write, and it ends the current burst.
- R2: A read accepted at clock edge E drives its data after edge E in flow-through mode (`flow_thru`=1) and after edge E+1 in pipelined mode (`flow_thru`=0). The data is driven for one cycle per beat, so a burst gives 2-1-1-1 or 3-1-1-1 spacing.
- R3: Write data on `din` is sampled one active edge after the write command in flow-through mode and two active edges after it in pipelined mode. `bw_n` is sampled with the command and is active low: bit i set to 0 writes bits [9i+8:9i].
- R4: A read always returns the newest data written to its address, including a write whose data arrives at the same edge that loads the read's output register. That pending data is merged with the array contents byte by byte, and no idle cycle is needed between reads and writes.
- R5: `adv`=1 continues the current read or write burst at its next beat, whatever the chip enables show. The upper address bits stay fixed. The low two bits are (start + n) mod 4 when `burst_lin`=1 and start XOR n when `burst_lin`=0, for beat n. The sequence wraps after four beats.
- R6: `adv`=1 when no burst is active (after reset or after a deselect cycle) performs no operation.
- R7: While `clk_en`=0, all inputs other than `oe_n` and `rst_n` are ignored. No write is committed, and the burst state, the pipeline and the output hold.
- R8: `oe_n`=1 forces `dout_drv` to 0 and `dout` to zero at once, without clocking, and leaves the internal state unchanged.
- R9: After reset, nothing is driven (`dout_drv`=0) and the burst controller is idle.
- R10: When no read data is due, `dout_drv` is 0 and `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | Static mode: 1 flow-through, 0 pipelined |
| burst_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| clk_en | input | 1 | Clock enable, active high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue the current burst |
| we_n | input | 1 | 0 write, 1 read (new commands) |
| bw_n | input | 4 | Per-byte write enables, active low |
| addr | input | 8 | Word address |
| din | input | 36 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Read data, zero when not driven |
| dout_drv | output | 1 | High while read data is driven |

## Verification
The sharpest corner case is a pipelined read issued right after a write to the same address, with only some bytes enabled. A design without forwarding returns stale bytes, and a design that ignores the byte enables during forwarding corrupts the unwritten ones. The sweeps start bursts at every low-address offset in both orders. An off-by-one or swapped order shows up as a wrong address in the readback. The bench also turns off each chip enable in turn, stalls with `clk_en` while writes are offered, and advances while idle. A design that commits a stalled or deselected write, or starts a phantom burst, leaves a word that miscompares later. Output-enable toggles expose any gating that is registered instead of immediate.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } burst_st_e;

    // low two address bits of beat n, from the burst start bits
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       lin);
        return lin ? (start + n) : (start ^ n);
    endfunction

endpackage

// File: rtl/zt_sram_seq.sv
`timescale 1ns/1ps
module zt_sram_seq
    import zt_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          lin,
    input  logic          adv,
    input  logic          sel,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          cmd_vld,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr
);

    burst_st_e     st_q, st_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;
    logic          start;

    assign start = !adv && sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (clk_en) begin
            st_q   <= st_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        cmd_vld  = 1'b0;
        cmd_wr   = 1'b0;
        cmd_addr = base_q;
        if (start) begin
            base_d   = addr;
            cnt_d    = 2'd0;
            cmd_vld  = 1'b1;
            cmd_wr   = !we_n;
            cmd_addr = addr;
            st_d     = we_n ? ST_RD : ST_WR;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RD, ST_WR: begin
                    if (adv) begin
                        cnt_d    = cnt_q + 2'd1;
                        cmd_vld  = 1'b1;
                        cmd_wr   = (st_q == ST_WR);
                        cmd_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_d, lin)};
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zt_sram_store.sv
`timescale 1ns/1ps
module zt_sram_store #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [NB-1:0]      wr_be,
    input  logic [NB*BW-1:0]   wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [NB*BW-1:0]   rd_data
);

    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= wr_data[b*BW +: BW];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/zt_sram_rdpath.sv
`timescale 1ns/1ps
module zt_sram_rdpath #(
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             ft,
    input  logic             acc_rd,
    input  logic [NB*BW-1:0] arr_data,
    input  logic             fwd_hit,
    input  logic [NB-1:0]    fwd_be,
    input  logic [NB*BW-1:0] fwd_data,
    input  logic             oe_n,
    output logic [NB*BW-1:0] dout,
    output logic             dout_drv
);

    localparam int DW = NB * BW;

    logic [DW-1:0] merged;
    logic [DW-1:0] q_data;
    logic          q_vld;
    logic [DW-1:0] sel_data;
    logic          sel_vld;

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*BW +: BW] = (fwd_hit && fwd_be[b]) ? fwd_data[b*BW +: BW]
                                                           : arr_data[b*BW +: BW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_data <= '0;
        end else if (clk_en) begin
            q_vld  <= acc_rd;
            q_data <= merged;
        end
    end

    always_comb begin
        sel_vld  = ft ? acc_rd : q_vld;
        sel_data = ft ? merged : q_data;
        dout_drv = sel_vld && !oe_n;
        dout     = dout_drv ? sel_data : '0;
    end

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flow_thru,
    input  logic                       burst_lin,
    input  logic                       clk_en,
    input  logic                       ce1_n,
    input  logic                       ce2,
    input  logic                       ce3_n,
    input  logic                       adv,
    input  logic                       we_n,
    input  logic [NBYTES-1:0]          bw_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NBYTES*BYTE_W-1:0]   din,
    input  logic                       oe_n,
    output logic [NBYTES*BYTE_W-1:0]   dout,
    output logic                       dout_drv
);

    localparam int DW = NBYTES * BYTE_W;

    logic              sel;
    logic              cmd_vld, cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;

    // access stage (command edge) and late-write stage (one edge later)
    logic              a_vld, a_wr, b_vld, b_wr;
    logic [ADDR_W-1:0] a_addr, b_addr;
    logic [NBYTES-1:0] a_be, b_be;

    logic              wr_en, fwd_hit;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;
    logic [DW-1:0]     arr_data;

    assign sel = !ce1_n && ce2 && !ce3_n;

    zt_sram_seq #(.AW(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .lin      (burst_lin),
        .adv      (adv),
        .sel      (sel),
        .we_n     (we_n),
        .addr     (addr),
        .cmd_vld  (cmd_vld),
        .cmd_wr   (cmd_wr),
        .cmd_addr (cmd_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld  <= 1'b0;
            a_wr   <= 1'b0;
            a_addr <= '0;
            a_be   <= '0;
            b_vld  <= 1'b0;
            b_wr   <= 1'b0;
            b_addr <= '0;
            b_be   <= '0;
        end else if (clk_en) begin
            a_vld  <= cmd_vld;
            a_wr   <= cmd_wr;
            a_addr <= cmd_addr;
            a_be   <= ~bw_n;
            b_vld  <= a_vld;
            b_wr   <= a_wr;
            b_addr <= a_addr;
            b_be   <= a_be;
        end
    end

    always_comb begin
        wr_en   = clk_en && (flow_thru ? (a_vld && a_wr) : (b_vld && b_wr));
        wr_addr = flow_thru ? a_addr : b_addr;
        wr_be   = flow_thru ? a_be : b_be;
        fwd_hit = !flow_thru && b_vld && b_wr && a_vld && !a_wr && (b_addr == a_addr);
    end

    zt_sram_store #(.AW(ADDR_W), .NB(NBYTES), .BW(BYTE_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (din),
        .rd_addr (a_addr),
        .rd_data (arr_data)
    );

    zt_sram_rdpath #(.NB(NBYTES), .BW(BYTE_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .ft       (flow_thru),
        .acc_rd   (a_vld && !a_wr),
        .arr_data (arr_data),
        .fwd_hit  (fwd_hit),
        .fwd_be   (b_be),
        .fwd_data (din),
        .oe_n     (oe_n),
        .dout     (dout),
        .dout_drv (dout_drv)
    );

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          flow_thru,
    input logic          burst_lin,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adv,
    input logic          oe_n,
    input logic          a_vld,
    input logic          a_wr,
    input logic [AW-1:0] a_addr,
    input logic          b_vld,
    input logic          dout_drv
);

    // R1
    desel_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && (ce1_n || !ce2 || ce3_n)) |=> !a_vld);

    // R2
    pipe_read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && clk_en && a_vld && !a_wr) |=> (dout_drv || oe_n));

    // R2
    flow_read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && a_vld && !a_wr && !oe_n) |-> dout_drv);

    // R5
    burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && a_vld) |=> (a_vld && a_addr[AW-1:2] == $past(a_addr[AW-1:2])
                                       && a_wr == $past(a_wr)));

    // R5
    burst_linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && a_vld && burst_lin) |=> (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1));

    // R6
    idle_adv_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && !a_vld) |=> !a_vld);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(a_vld) && $stable(a_addr) && $stable(b_vld)));

    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_drv);

endmodule

bind zt_sram zt_sram_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .flow_thru (flow_thru),
    .burst_lin (burst_lin),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .adv       (adv),
    .oe_n      (oe_n),
    .a_vld     (a_vld),
    .a_wr      (a_wr),
    .a_addr    (a_addr),
    .b_vld     (b_vld),
    .dout_drv  (dout_drv)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_thru = 1'b0, burst_lin = 1'b0, clk_en = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic        adv = 1'b0, we_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic [7:0]  addr = '0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_drv;

    zt_sram uut (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .burst_lin(burst_lin),
        .clk_en(clk_en), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv),
        .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_drv(dout_drv)
    );

    always #2.5 clk = ~clk;

    int nvec = 0, nfail = 0;
    bit done = 0;
    logic [31:0] rs = 32'h1234_5678;

    // reference model
    logic [35:0] ref_mem [256];
    int          m_st;            // 0 idle, 1 read burst, 2 write burst
    logic [7:0]  m_base;
    logic [1:0]  m_cnt;
    logic        p1_vld, p1_wr, p2_vld, p2_wr;
    logic [7:0]  p1_addr, p2_addr;
    logic [3:0]  p1_be, p2_be;
    logic        exp_vld;
    logic [35:0] exp_data;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    task automatic model_reset();
        m_st = 0; m_base = '0; m_cnt = '0;
        p1_vld = 0; p1_wr = 0; p1_addr = '0; p1_be = '0;
        p2_vld = 0; p2_wr = 0; p2_addr = '0; p2_be = '0;
        exp_vld = 0; exp_data = '0;
    endtask

    task automatic sample(input string tag);
        logic e_drv;
        logic [35:0] e_out;
        e_drv = exp_vld && !oe_n;
        e_out = e_drv ? exp_data : 36'h0;
        nvec++;
        if (dout_drv !== e_drv || dout !== e_out) begin
            nfail++;
            $display("FAIL %s: drv=%0b dout=%h expected drv=%0b dout=%h",
                     tag, dout_drv, dout, e_drv, e_out);
        end
    endtask

    // one clock: check outputs, drive inputs, advance the model for the coming edge
    task automatic step(input bit ce, input bit a, input logic [2:0] cev, input bit wn,
                        input logic [3:0] bwn, input logic [7:0] ad, input bit oe,
                        input string tag);
        logic        c_vld, c_wr, s_vld, s_wr, r_vld, r_wr;
        logic [7:0]  c_addr, s_addr, r_addr;
        logic [3:0]  c_be, s_be;
        logic [1:0]  lo;
        logic [35:0] d;
        @(negedge clk);
        sample(tag);
        rs = nxt(rs); d[31:0] = rs;
        rs = nxt(rs); d[35:32] = rs[3:0];
        clk_en = ce; adv = a; {ce1_n, ce2, ce3_n} = cev; we_n = wn;
        bw_n = bwn; addr = ad; oe_n = oe; din = d;
        if (ce) begin
            c_vld = 0; c_wr = 0; c_addr = '0; c_be = ~bwn;
            if (!a && cev == 3'b010) begin
                c_vld = 1; c_wr = !wn; c_addr = ad;
                m_base = ad; m_cnt = 0; m_st = wn ? 1 : 2;
            end else if (a && m_st != 0) begin
                m_cnt = m_cnt + 2'd1;
                lo = burst_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
                c_vld = 1; c_wr = (m_st == 2); c_addr = {m_base[7:2], lo};
            end else begin
                m_st = 0;
            end
            // late write committed at this edge
            s_vld  = flow_thru ? p1_vld : p2_vld;
            s_wr   = flow_thru ? p1_wr : p2_wr;
            s_addr = flow_thru ? p1_addr : p2_addr;
            s_be   = flow_thru ? p1_be : p2_be;
            if (s_vld && s_wr)
                for (int b = 0; b < 4; b++)
                    if (s_be[b]) ref_mem[s_addr][b*9 +: 9] = d[b*9 +: 9];
            // read whose data is shown after this edge
            r_vld  = flow_thru ? c_vld : p1_vld;
            r_wr   = flow_thru ? c_wr : p1_wr;
            r_addr = flow_thru ? c_addr : p1_addr;
            exp_vld  = r_vld && !r_wr;
            exp_data = ref_mem[r_addr];
            p2_vld = p1_vld; p2_wr = p1_wr; p2_addr = p1_addr; p2_be = p1_be;
            p1_vld = c_vld;  p1_wr = c_wr;  p1_addr = c_addr;  p1_be = c_be;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] ax;
        logic [2:0] cv;
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        for (int cfg = 0; cfg < 4; cfg++) begin
            // R9: reset state
            @(negedge clk);
            rst_n = 0; flow_thru = cfg[1]; burst_lin = cfg[0];
            clk_en = 0; adv = 0; {ce1_n, ce2, ce3_n} = 3'b101; oe_n = 0;
            model_reset();
            repeat (3) @(negedge clk);
            nvec++;
            if (dout_drv !== 1'b0 || dout !== 36'h0) begin
                nfail++;
                $display("FAIL R9: drv=%0b dout=%h expected drv=0 dout=0", dout_drv, dout);
            end
            rst_n = 1;

            // R3/R5: fill every word with write bursts from every start offset
            for (int g = 0; g < 64; g++) begin
                step(1, 0, 3'b010, 0, 4'h0, 8'(g*4 + (g % 4)), 0, "R3");
                for (int k = 0; k < 3; k++) step(1, 1, 3'b010, 0, 4'h0, 8'h00, 0, "R3");
            end
            // R2/R5: read back every word with bursts
            for (int g = 0; g < 64; g++) begin
                step(1, 0, 3'b010, 1, 4'hF, 8'(g*4 + ((g + 1) % 4)), 0, "R2");
                for (int k = 0; k < 3; k++) step(1, 1, 3'b101, 0, 4'h0, 8'hFF, 0, "R5");
            end
            // R4: write then immediate reads of the same word, partial bytes
            for (int i = 0; i < 8; i++) begin
                step(1, 0, 3'b010, 0, 4'b1010, 8'(8'h30 + i), 0, "R4");
                step(1, 0, 3'b010, 1, 4'hF, 8'(8'h30 + i), 0, "R4");
                step(1, 0, 3'b010, 1, 4'hF, 8'(8'h30 + i), 0, "R4");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R4");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R4");
            end
            // R1: writes with each chip enable inactive in turn, then read back
            for (int k = 0; k < 3; k++) begin
                cv = 3'b010 ^ (3'b100 >> k);
                step(1, 0, cv, 0, 4'h0, 8'h50, 0, "R1");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R1");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R1");
                step(1, 0, 3'b010, 1, 4'hF, 8'h50, 0, "R1");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R1");
                step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R1");
            end
            // R7: stall right after a read and a write, with writes offered
            step(1, 0, 3'b010, 0, 4'h0, 8'h61, 0, "R7");
            step(1, 0, 3'b010, 1, 4'hF, 8'h60, 0, "R7");
            for (int k = 0; k < 3; k++) step(0, 0, 3'b010, 0, 4'h0, 8'h60, 0, "R7");
            for (int k = 0; k < 3; k++) step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R7");
            step(1, 0, 3'b010, 1, 4'hF, 8'h60, 0, "R7");
            step(1, 0, 3'b010, 1, 4'hF, 8'h61, 0, "R7");
            for (int k = 0; k < 3; k++) step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R7");
            // R6: advance with no active burst, then read the offered address
            step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R6");
            step(1, 1, 3'b010, 0, 4'h0, 8'h70, 0, "R6");
            step(1, 1, 3'b010, 1, 4'hF, 8'h70, 0, "R6");
            step(1, 0, 3'b010, 1, 4'hF, 8'h70, 0, "R6");
            for (int k = 0; k < 3; k++) step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R10");
            // R8 and R4: random mixed traffic on a small window
            for (int i = 0; i < 1500; i++) begin
                logic [31:0] r;
                rs = nxt(rs); r = rs;
                ax = {4'h8, r[3:0]};
                case (r[7:4])
                    4'd0:    cv = 3'b110;
                    4'd1:    cv = 3'b000;
                    4'd2:    cv = 3'b011;
                    default: cv = 3'b010;
                endcase
                step(r[10:8] != 3'd0, r[11] & r[12], cv, r[13], r[17:14], ax,
                     r[20:18] == 3'd0, (r[20:18] == 3'd0) ? "R8" : "R4");
            end
            for (int k = 0; k < 3; k++) step(1, 0, 3'b101, 1, 4'hF, 8'h00, 0, "R10");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule